// File: doc/BRIEF.md
# Baud Clock Generator

This block produces the bit-rate enable pulse shared by the transmit and receive halves of a serial port. A two-bit select picks where its ticks come from: every cycle of the system clock, one cycle in eight of the system clock, or each rising edge of an external serial clock input. The external input is resynchronised into the system clock domain first. A programmable 16-bit divisor then turns those source ticks into a one-cycle baud enable, `baud_tick`. Both halves of the port sample this enable, so they always run at exactly the same bit rate.

There are two special divisor values. A divisor of zero switches the output off completely. A divisor of one bypasses the counter, so every source tick passes straight through. When the select or the divisor changes, the counter and the prescaler start again from zero. The first period after a change is then always a full one. No data stream crosses this block, so every pin is a plain level or pulse and there is no valid/ready handshake. The output is a bare enable that cannot be stalled. Consumers must act on it in the cycle it is high.

Top module: `baud_clock_gen`

## Requirements
- R1: `src_sel` encodings: 2'b00 makes every system clock cycle a source tick. 2'b01 makes one cycle in every PRESCALE (default 8) a source tick. 2'b10 makes each synchronised rising edge of `ext_clk` a source tick.
- R2: The divisor is DIV_W (default 16) bits wide. Every value from 2 up to 65535 gives a `baud_tick` period of exactly that many source ticks.
- R3: While `divisor` is 0, `baud_tick` stays low whatever the source.
- R4: `ext_clk` passes through a two-flop synchroniser. Only its rising edges count: one source tick per rising edge, a fixed 2 cycles after the edge is first captured. Toggling `ext_clk` has no effect on the output when another source is selected.
- R5: With `divisor` equal to 1, `baud_tick` equals the source tick in every cycle.
- R6: With `divisor` of 2 or more, `baud_tick` is a single-cycle pulse. The first pulse comes on the N-th source tick after a restart, and pulses follow every N ticks after that.
- R7: Any change of `src_sel` or `divisor` suppresses `baud_tick` in the cycle of the change. It also restarts the divider and prescaler from zero, so the next pulse comes a full N source ticks later.
- R8: `src_sel` of 2'b11 is reserved and yields no source ticks, so `baud_tick` stays low.
- R9: Synchronous active-high `rst` holds `baud_tick` low and clears all counters and the synchroniser. Leaving reset behaves like a restart (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source select (see R1, R8) |
| divisor | input | 16 | Divide ratio in source ticks |
| ext_clk | input | 1 | External serial clock, asynchronous |
| baud_tick | output | 1 | One-cycle baud enable |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a prescale of 8 and two synchroniser stages. At these values, the widest divisor (65535) fits inside the run, so the boundary at the top of the divider is checked directly. A prescale of 8 keeps the prescaled periods short enough that several full periods fit in each window. The external clock is driven with a period of six cycles. This is long enough for the synchroniser to resolve every edge, and short enough to show the effect of the divisor on an edge-driven source.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_SYS      = 2'b00,
    SRC_PRESCALE = 2'b01,
    SRC_EXTERNAL = 2'b10,
    SRC_NONE     = 2'b11
  } baud_src_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/bclk_cfg_watch.sv
// Flags any change of the configuration word so that the counters restart.
module bclk_cfg_watch #(
  parameter int unsigned CFG_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  output logic             restart
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg;
  end

  assign restart = (cfg != cfg_q);
endmodule

// File: rtl/bclk_prescaler.sv
// Fixed divide of the system clock, producing one tick every PRESCALE cycles.
module bclk_prescaler #(
  parameter int unsigned PRESCALE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk) begin
        if (rst || restart)     pcnt_q <= '0;
        else if (pcnt_q == LAST) pcnt_q <= '0;
        else                     pcnt_q <= pcnt_q + PW'(1);
      end

      assign tick = (pcnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/bclk_ext_sync.sv
// Multi-flop synchroniser for the external clock with rising-edge detect.
module bclk_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= ext_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bclk_divider.sv
// Counts source ticks and emits the baud enable; handles 0 (off) and 1 (bypass).
module bclk_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] count,
  output logic             tick_out
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_off;
  logic             div_bypass;
  logic             at_last;

  assign div_off    = (divisor == '0);
  assign div_bypass = (divisor == DIV_W'(1));
  assign at_last    = (cnt_q == divisor - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (!div_off && !div_bypass && src_tick) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  always_comb begin
    if (rst || restart || div_off) tick_out = 1'b0;
    else if (div_bypass)           tick_out = src_tick;
    else                           tick_out = src_tick & at_last;
  end

  assign count = cnt_q;
endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned PRESCALE    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ext_clk,
  output logic             baud_tick
);
  localparam int unsigned CFG_W = SEL_W + DIV_W;

  logic             restart;
  logic             pre_tick;
  logic             ext_tick;
  logic             src_tick;
  logic [DIV_W-1:0] div_count;

  bclk_cfg_watch #(.CFG_W(CFG_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .cfg     ({src_sel, divisor}),
    .restart (restart)
  );

  bclk_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (pre_tick)
  );

  bclk_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .ext_in (ext_clk),
    .rise   (ext_tick)
  );

  always_comb begin
    unique case (baud_src_e'(src_sel))
      SRC_SYS:      src_tick = 1'b1;
      SRC_PRESCALE: src_tick = pre_tick;
      SRC_EXTERNAL: src_tick = ext_tick;
      default:      src_tick = 1'b0;
    endcase
  end

  bclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .src_tick (src_tick),
    .divisor  (divisor),
    .count    (div_count),
    .tick_out (baud_tick)
  );
endmodule

// File: rtl/bclk_checker.sv
module bclk_checker #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       src_sel,
  input logic [DIV_W-1:0] divisor,
  input logic             baud_tick,
  input logic             src_tick,
  input logic             ext_tick,
  input logic [DIV_W-1:0] div_count
);
  // R3: divisor zero silences the output
  a_r3_zero_silent: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |-> !baud_tick);

  // R8: reserved select yields nothing
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b11) |-> !baud_tick);

  // R6: pulse lasts one cycle when dividing
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && divisor > DIV_W'(1)) |=> !baud_tick);

  // R7: no output in the cycle the configuration changes
  a_r7_change_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable({src_sel, divisor}) |-> !baud_tick);

  // R5: bypass follows the source tick
  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    (divisor == DIV_W'(1) && $stable({src_sel, divisor}) && !$past(rst) && src_tick)
      |-> baud_tick);

  // R4: one tick per external rising edge
  a_r4_edge_single: assert property (@(posedge clk) disable iff (rst)
    ext_tick |=> !ext_tick);

  // R2: counter stays below the divisor
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    (divisor > DIV_W'(1) && $stable({src_sel, divisor}) && !$past(rst))
      |-> (div_count < divisor));

  // R9: reset holds the output low
  always @(negedge clk) begin
    if (rst) a_r9_reset_low: assert (!baud_tick);
  end
endmodule

bind baud_clock_gen bclk_checker #(.DIV_W(DIV_W)) i_bclk_checker (
  .clk       (clk),
  .rst       (rst),
  .src_sel   (src_sel),
  .divisor   (divisor),
  .baud_tick (baud_tick),
  .src_tick  (src_tick),
  .ext_tick  (ext_tick),
  .div_count (div_count)
);

// File: tb/test_baud_clock_gen.sv
module test_baud_clock_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'b00;
  logic [15:0] divisor = 16'd1;
  logic        ext_clk = 1'b0;
  logic        baud_tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;  // 50 MHz

  baud_clock_gen i_baud_clock_gen (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .divisor   (divisor),
    .ext_clk   (ext_clk),
    .baud_tick (baud_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply a configuration at a falling edge.
  task automatic set_cfg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    src_sel = s;
    divisor = d;
  endtask

  // Observe `cycles` samples. Toggle ext_clk every ext_half samples (0 = never).
  task automatic measure(input int cycles, input int ext_half, input int exp_gap,
                         output int cnt, output int first, output int bad_gap);
    int last;
    cnt = 0; first = -1; bad_gap = 0; last = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (baud_tick) begin
        if (cnt == 0) first = k;
        else if (k - last != exp_gap) bad_gap++;
        last = k;
        cnt++;
      end
      if (ext_half > 0 && (k % ext_half) == 0) ext_clk = ~ext_clk;
    end
  endtask

  task automatic t_reset;
    int cnt, first, bad;
    rst = 1'b1;
    set_cfg(2'b00, 16'd1);
    measure(5, 0, 1, cnt, first, bad);
    chk("R9 output low in reset", cnt, 0);
    @(negedge clk);
    rst = 1'b0;
    measure(10, 0, 1, cnt, first, bad);
    chk("R9 restart after reset first", first, 1);
  endtask

  task automatic t_sys_bypass;
    int cnt, first, bad;
    set_cfg(2'b00, 16'd1);
    set_cfg(2'b00, 16'd1);
    measure(20, 0, 1, cnt, first, bad);
    chk("R5 bypass every cycle", cnt, 20);
  endtask

  task automatic t_sys_divide;
    int cnt, first, bad;
    set_cfg(2'b00, 16'd5);
    measure(40, 0, 5, cnt, first, bad);
    chk("R6 div5 first pulse", first, 5);
    chk("R6 div5 count", cnt, 8);
    chk("R6 div5 gaps", bad, 0);
    set_cfg(2'b00, 16'd2);
    measure(20, 0, 2, cnt, first, bad);
    chk("R6 div2 count", cnt, 10);
    chk("R6 div2 gaps", bad, 0);
  endtask

  task automatic t_max_divisor;
    int cnt, first, bad;
    set_cfg(2'b00, 16'hFFFF);
    measure(65540, 0, 65535, cnt, first, bad);
    chk("R2 max divisor first", first, 65535);
    chk("R2 max divisor count", cnt, 1);
  endtask

  task automatic t_zero;
    int cnt, first, bad;
    set_cfg(2'b00, 16'd0);
    measure(50, 0, 1, cnt, first, bad);
    chk("R3 zero sys", cnt, 0);
    set_cfg(2'b10, 16'd0);
    measure(48, 3, 1, cnt, first, bad);
    chk("R3 zero ext", cnt, 0);
    ext_clk = 1'b0;
  endtask

  task automatic t_prescale;
    int cnt, first, bad;
    set_cfg(2'b01, 16'd1);
    measure(40, 0, 8, cnt, first, bad);
    chk("R1 prescale first", first, 8);
    chk("R1 prescale count", cnt, 5);
    set_cfg(2'b01, 16'd3);
    measure(100, 0, 24, cnt, first, bad);
    chk("R1 prescale div3 first", first, 24);
    chk("R1 prescale div3 count", cnt, 4);
    chk("R1 prescale div3 gaps", bad, 0);
  endtask

  task automatic t_external;
    int cnt, first, bad;
    ext_clk = 1'b0;
    set_cfg(2'b10, 16'd1);
    measure(4, 0, 1, cnt, first, bad);  // let the synchroniser settle
    set_cfg(2'b10, 16'd2);
    set_cfg(2'b10, 16'd1);
    measure(60, 3, 6, cnt, first, bad);
    chk("R4 ext edge first", first, 5);
    chk("R4 ext edge count", cnt, 10);
    chk("R4 ext edge gaps", bad, 0);
    ext_clk = 1'b0;
    measure(4, 0, 1, cnt, first, bad);
    set_cfg(2'b10, 16'd2);
    measure(60, 3, 12, cnt, first, bad);
    chk("R1 ext div2 first", first, 11);
    chk("R1 ext div2 count", cnt, 5);
    chk("R1 ext div2 gaps", bad, 0);
    ext_clk = 1'b0;
  endtask

  task automatic t_ext_ignored;
    int cnt, first, bad;
    set_cfg(2'b00, 16'd3);
    measure(30, 2, 3, cnt, first, bad);
    chk("R4 ext ignored count", cnt, 10);
    chk("R4 ext ignored gaps", bad, 0);
    ext_clk = 1'b0;
  endtask

  task automatic t_restart;
    int cnt, first, bad;
    set_cfg(2'b00, 16'd10);
    measure(6, 0, 10, cnt, first, bad);
    chk("R7 no pulse before change", cnt, 0);
    set_cfg(2'b00, 16'd4);
    measure(20, 0, 4, cnt, first, bad);
    chk("R7 full period after change", first, 4);
    chk("R7 count after change", cnt, 5);
    set_cfg(2'b01, 16'd4);
    measure(70, 0, 32, cnt, first, bad);
    chk("R7 source change first", first, 32);
    chk("R7 source change count", cnt, 2);
  endtask

  task automatic t_reserved;
    int cnt, first, bad;
    set_cfg(2'b11, 16'd1);
    measure(40, 3, 1, cnt, first, bad);
    chk("R8 reserved select", cnt, 0);
    ext_clk = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sys_bypass();
    t_sys_divide();
    t_zero();
    t_prescale();
    t_external();
    t_ext_ignored();
    t_restart();
    t_reserved();
    t_max_divisor();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule